// File: doc/BRIEF.md
# Strap-latched frequency select controller

This block produces the 5-bit code that sets the operating point of a clock synthesizer. Three of the five select inputs share pins with clock outputs. For that reason the block keeps those pins as inputs while a fixed settle count runs after reset. On the last cycle of the count it captures all five strap inputs. It then enables the output drivers of the shared pins. The captured value stays fixed until the next reset.

Once the straps are captured, a configuration byte chooses the source of the code. The code comes either from the captured straps or from five software bits. These software bits sit at non-adjacent positions in the byte. The block registers the chosen code and decodes the spread-spectrum mode that goes with it. When the registered code takes a new value, the block raises a one-cycle update pulse so the synthesizer can reprogram. Programming the PLL is not part of this block.

Top module: `fsel_ctrl`

## Requirements
- R1: While rst_ni is low, code_o is 0, spread_o is 0, pin_oe_o is 0 and upd_o is 0.
- R2: After reset release, pin_oe_o stays 0 through the first SETTLE_CYC-1 rising edges. It becomes all ones on edge SETTLE_CYC and keeps that value until the next reset.
- R3: The hardware code is the value of strap_i at edge SETTLE_CYC after reset release. strap_i has no effect at any other edge. Bit i of strap_i is select bit i.
- R4: Once the straps are captured, cfg_i bit 3 selects the code source: 0 selects the captured straps and 1 selects the software code. code_o follows a change of cfg_i or of the source on the next rising edge. The first load takes place on edge SETTLE_CYC+1.
- R5: The software code is formed as follows: bit 4 from cfg_i[2], bit 3 from cfg_i[1], bit 2 from cfg_i[6], bit 1 from cfg_i[5] and bit 0 from cfg_i[4]. cfg_i bits 0 and 7 have no effect.
- R6: spread_o is a function of code_o. It is 1 (center ±0.25%) for codes 10000, 10001 and 10011. It is 2 (center ±0.5%) for 10100, 10101 and 10111. It is 3 (down −0.5%) for 11100, 11101 and 11111. It is 0 (off) for every other code.
- R7: upd_o is 1 for exactly the first cycle in which code_o shows a value different from the previous cycle. Otherwise it is 0. A captured code of 0 therefore raises no pulse.
- R8: Until edge SETTLE_CYC+1, code_o stays 0 and upd_o stays 0, whatever the values of cfg_i and strap_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 5 | Strap pin levels, bit i = select bit i |
| cfg_i | input | 8 | Configuration byte with the source bit and the software select bits |
| code_o | output | 5 | Active frequency-select code |
| spread_o | output | 2 | Spread mode: 0 off, 1 center ±0.25%, 2 center ±0.5%, 3 down −0.5% |
| pin_oe_o | output | 3 | Output enables of the shared pins for select bits 2, 3 and 4 |
| upd_o | output | 1 | One-cycle pulse when code_o changes |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that strap_i and cfg_i change only between clock edges, so every captured value is a clean level. The bench changes all inputs on the falling edge. It drives random strap values during the settle window and on the cycles that follow it, and places the intended strap value only at the capture edge. It also toggles random bits of cfg_i while the window is still open. Beyond these cases, it walks the source bit and all 32 software codes, with junk in the unused bits of cfg_i.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int unsigned CODE_W  = 5;
  localparam int unsigned CFG_W   = 8;
  localparam int unsigned SRC_BIT = 3;
  // cfg bit position feeding each code bit, index = code bit
  localparam int unsigned SW_POS [CODE_W] = '{4, 5, 6, 1, 2};

  typedef enum logic [1:0] {
    SPR_OFF       = 2'd0,
    SPR_CTR_QTR   = 2'd1,
    SPR_CTR_HALF  = 2'd2,
    SPR_DOWN_HALF = 2'd3
  } spread_e;
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] strap_i,
  output logic [CODE_W-1:0] strap_q_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] strap_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      strap_q <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        strap_q <= strap_i;
        done_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign strap_q_o = strap_q;
  assign done_o    = done_q;

  // R2
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  // R3
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(strap_q));
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/fsel_src_mux.sv
module fsel_src_mux
  import fsel_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [CODE_W-1:0] hw_code_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] sw_code;

  for (genvar g = 0; g < CODE_W; g++) begin : g_sw
    assign sw_code[g] = cfg_i[SW_POS[g]];
  end

  assign code_o = cfg_i[SRC_BIT] ? sw_code : hw_code_i;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_i[7], cfg_i[0]};
endmodule

// File: rtl/fsel_spread_dec.sv
module fsel_spread_dec
  import fsel_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output spread_e           spread_o
);
  always_comb begin
    spread_o = SPR_OFF;
    if (code_i[4] && code_i[1:0] != 2'b10) begin
      unique case (code_i[3:2])
        2'b00:   spread_o = SPR_CTR_QTR;
        2'b01:   spread_o = SPR_CTR_HALF;
        2'b11:   spread_o = SPR_DOWN_HALF;
        default: spread_o = SPR_OFF;
      endcase
    end
  end
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned N_SHARED   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   strap_i,
  input  logic [CFG_W-1:0]    cfg_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [1:0]          spread_o,
  output logic [N_SHARED-1:0] pin_oe_o,
  output logic                upd_o
);
  logic [CODE_W-1:0] strap_q, code_nxt, code_q;
  logic              done;
  logic              upd_q;
  spread_e           spread;

  fsel_strap_latch #(.SETTLE_CYC(SETTLE_CYC)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .strap_q_o (strap_q),
    .done_o    (done)
  );

  fsel_src_mux u_mux (
    .cfg_i     (cfg_i),
    .hw_code_i (strap_q),
    .code_o    (code_nxt)
  );

  // code register loads only once straps are valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= done && (code_nxt != code_q);
      if (done) code_q <= code_nxt;
    end
  end

  fsel_spread_dec u_dec (
    .code_i   (code_q),
    .spread_o (spread)
  );

  assign code_o   = code_q;
  assign spread_o = spread;
  assign pin_oe_o = {N_SHARED{done}};
  assign upd_o    = upd_q;

  // R7
  upd_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> upd_q);
  // R7
  upd_only_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (code_q != $past(code_q)));
  // R8
  hold_before_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> (code_q == '0));
  // R6
  spread_low_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_o[4] |-> (spread_o == 2'd0));
  // R2
  oe_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pin_oe_o) == 0 || $countones(pin_oe_o) == N_SHARED);
endmodule

// File: tb/fsel_ctrl_test.sv
module fsel_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] strap_i = '0;
  logic [7:0] cfg_i = '0;
  logic [4:0] code_o;
  logic [1:0] spread_o;
  logic [2:0] pin_oe_o;
  logic       upd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;
  logic [4:0] latched, prev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fsel_ctrl #(.SETTLE_CYC(SETTLE)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .cfg_i(cfg_i),
    .code_o(code_o), .spread_o(spread_o), .pin_oe_o(pin_oe_o), .upd_o(upd_o)
  );

  function automatic logic [4:0] sw_code(input logic [7:0] c);
    return {c[2], c[1], c[6], c[5], c[4]};
  endfunction

  function automatic logic [1:0] exp_spr(input logic [4:0] c);
    case (c)
      5'b10000, 5'b10001, 5'b10011: return 2'd1;
      5'b10100, 5'b10101, 5'b10111: return 2'd2;
      5'b11100, 5'b11101, 5'b11111: return 2'd3;
      default:                      return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] cfg_for(input logic [4:0] c, input logic [7:0] junk);
    logic [7:0] r = junk;
    r[3] = 1'b1; r[2] = c[4]; r[1] = c[3]; r[6] = c[2]; r[5] = c[1]; r[4] = c[0];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input logic [4:0] v);
    rst_ni = 1'b0;
    strap_i = 5'($urandom);
    cfg_i = 8'($urandom);
    repeat (2) @(negedge clk_i);
    chk("R1 code", code_o, 0);
    chk("R1 spread", spread_o, 0);
    chk("R1 oe", pin_oe_o, 0);
    chk("R1 upd", upd_o, 0);
    rst_ni = 1'b1;
    for (int i = 1; i <= SETTLE; i++) begin
      strap_i = (i == SETTLE) ? v : 5'($urandom);
      cfg_i = 8'($urandom);
      @(posedge clk_i); @(negedge clk_i);
      chk("R2 oe", pin_oe_o, (i == SETTLE) ? 3'b111 : 3'b000);
      chk("R8 code", code_o, 0);
      chk("R8 upd", upd_o, 0);
    end
    latched = v;
    strap_i = ~v;
    cfg_i = 8'($urandom) & 8'hF7;
    @(posedge clk_i); @(negedge clk_i);
    chk("R3 code", code_o, v);
    chk("R7 upd", upd_o, v != 0);
    chk("R6 spread", spread_o, exp_spr(v));
    prev = v;
  endtask

  task automatic step(input logic [7:0] c, input logic [4:0] s);
    logic [4:0] e;
    cfg_i = c;
    strap_i = s;
    e = c[3] ? sw_code(c) : latched;
    @(posedge clk_i); @(negedge clk_i);
    chk(c[3] ? "R5 code" : "R4 code", code_o, e);
    chk("R7 upd", upd_o, e != prev);
    chk("R6 spread", spread_o, exp_spr(e));
    chk("R2 oe", pin_oe_o, 3'b111);
    prev = e;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    settle(5'b10011);
    // R5 R6: walk all software codes, junk in bits 0 and 7
    for (int c = 0; c < 32; c++) step(cfg_for(5'(c), 8'($urandom)), 5'($urandom));
    // R7: same code twice gives no second pulse
    step(cfg_for(5'b11101, 8'h81), 5'd0);
    step(cfg_for(5'b11101, 8'h00), 5'd31);
    // R4: back to hardware source
    step(8'h00, 5'd7);
    // random mix
    for (int k = 0; k < 300; k++) step(8'($urandom), 5'($urandom));
    // R7: zero strap raises no pulse
    settle(5'b00000);
    for (int k = 0; k < 100; k++) step(8'($urandom), 5'($urandom));
    settle(5'b11100);
    for (int k = 0; k < 100; k++) step(8'($urandom), 5'($urandom));
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule